// File: doc/BRIEF.md
# Burst Transmit Sequencer

This controller steps one time-slotted radio transmit burst, or a chain of bursts, through its life. Pending data in the transmit FIFO starts a build. A message builder reports when the burst is assembled or has overflowed. The host arms the transmission with a start command. A slot timer strobes the requested transmit point, and an end-of-message strobe closes each burst. The controller drives a group of RF enables, a PA ramp request and a 4-bit state code, and raises a one-cycle done interrupt whenever a burst ends or is abandoned.

Several bursts can be sent back to back. If more data is waiting when a burst ends, the RF group stays on while the PA ramps down. The controller then waits a fixed dwell, rebuilds, and goes out on the next slot strobe without a new start command. Three abort states report a late buffer, a busy channel or an oversized message. Each has its own way out. The host reset input overrides everything and returns the block to idle. If the RF was on, the PA is ramped down first and the enables are released a fixed number of cycles later.

Top module: `burst_tx_seq`

## Requirements
- R1: After `rst`, `state_code` is 0 (idle), `tx_done` is 0, `pa_ramp_up` is 0 and `rf_en` is all zeros. A `host_reset` cycle forces the state to 0 from any state, whatever the other inputs are doing.
- R2: On a `host_reset` while the RF group is on, `pa_ramp_up` falls in the same cycle as the state change. `rf_en` stays all ones for RAMP_CYCLES further clock edges and then clears.
- R3: In idle (code 0), `fifo_has_data` moves the state to building (code 1). While the state is in an abort code, `fifo_has_data` has no effect.
- R4: In building, `build_done` goes to pending (code 3) if `host_start` was seen since the build began or arrives with it. Otherwise it goes to buffer ready (code 2). Buffer ready ignores `slot_strobe` and moves to pending on `host_start`.
- R5: In pending, a `slot_strobe` without a detected busy channel moves to in progress (code 4), sets every `rf_en` bit and raises `pa_ramp_up`. `carrier_det` is ignored when `cs_mode_en` is 0.
- R6: In progress, `eom_strobe` with the FIFO empty returns the state to 0, pulses `tx_done` for one cycle and drops `pa_ramp_up`. `rf_en` clears RAMP_CYCLES edges later.
- R7: In progress, `eom_strobe` with the FIFO non-empty moves to chained (code 5). `rf_en` stays on and `pa_ramp_up` falls. After exactly CLK_MHZ*DWELL_US cycles in code 5 the state becomes building (code 1). `build_done` then goes to pending with no start command, and the next `slot_strobe` sends it (code 4).
- R8: A `slot_strobe` in building moves the state to 9 (buffer not ready) and pulses `tx_done`. In code 9, `build_done` leads to buffer ready (code 2), or to pending if `host_start` was given in code 9.
- R9: In pending with `cs_mode_en` and `carrier_det` both 1, a `slot_strobe` moves the state to 10 (carrier sensed) and pulses `tx_done`. In code 10, `host_start` reschedules directly to pending.
- R10: `build_overflow` in building moves the state to 8 (message too long) and pulses `tx_done`. Code 8 ignores `fifo_has_data`, `build_done`, `host_start` and `slot_strobe`, and only `host_reset` leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_has_data | input | 1 | Transmit FIFO holds at least one word |
| build_done | input | 1 | Builder finished assembling the burst |
| build_overflow | input | 1 | Builder ran out of buffer space |
| host_start | input | 1 | Host start command |
| host_reset | input | 1 | Host state reset command |
| slot_strobe | input | 1 | Requested transmit point reached |
| cs_mode_en | input | 1 | Enables carrier-sense abort |
| carrier_det | input | 1 | Carrier present on the channel |
| eom_strobe | input | 1 | Modulator finished the current burst |
| rf_en | output | RF_W | RF enable group |
| pa_ramp_up | output | 1 | 1 requests PA ramp up, 0 ramp down |
| state_code | output | 4 | Current sequencing state code |
| tx_done | output | 1 | One-cycle burst-ended interrupt |

## Verification
State code, `tx_done` and `pa_ramp_up` are all registered from the same next-state logic. Each of them therefore answers an input on the first rising edge after it is applied. The bench drives inputs on the falling edge and samples just after the following rising edge. `rf_en` is the one delayed output: on release it clears RAMP_CYCLES edges after the state change. The bench counts those edges one by one and checks the last cycle it must still be high as well as the first cycle it must be low. The chained dwell is checked the same way: the bench counts the exact edge on which code 5 gives way to code 1.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_BUILD    = 4'd1,
    ST_READY    = 4'd2,
    ST_PEND     = 4'd3,
    ST_ACTIVE   = 4'd4,
    ST_CHAIN    = 4'd5,
    ST_ERR_LONG = 4'd8,
    ST_ERR_LATE = 4'd9,
    ST_ERR_BUSY = 4'd10
  } tx_state_e;

  function automatic logic holds_rf(input tx_state_e s, input logic chained);
    return (s == ST_ACTIVE) || (s == ST_CHAIN) ||
           (chained && ((s == ST_BUILD) || (s == ST_PEND)));
  endfunction

endpackage

// File: rtl/bts_dwell_timer.sv
module bts_dwell_timer #(
  parameter int unsigned CLK_MHZ  = 250,
  parameter int unsigned DWELL_US = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int unsigned DWELL_CYC = CLK_MHZ * DWELL_US;
  localparam int unsigned CNT_W     = $clog2(DWELL_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);
endmodule

// File: rtl/bts_rf_sequencer.sv
module bts_rf_sequencer #(
  parameter int unsigned RF_W        = 3,
  parameter int unsigned RAMP_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            keep_rf_nxt,
  input  logic            pa_on_nxt,
  output logic [RF_W-1:0] rf_en,
  output logic            pa_ramp_up
);
  localparam int unsigned CNT_W = $clog2(RAMP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RAMP_CYCLES - 1);

  logic             on_q;
  logic             drain_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q       <= 1'b0;
      drain_q    <= 1'b0;
      cnt_q      <= '0;
      pa_ramp_up <= 1'b0;
    end else begin
      pa_ramp_up <= pa_on_nxt;
      if (keep_rf_nxt) begin
        on_q    <= 1'b1;
        drain_q <= 1'b0;
        cnt_q   <= '0;
      end else if (on_q && !drain_q) begin
        drain_q <= 1'b1;
        cnt_q   <= '0;
      end else if (drain_q) begin
        if (cnt_q == LAST) begin
          on_q    <= 1'b0;
          drain_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < RF_W; g++) begin : g_rf
    assign rf_en[g] = on_q;
  end
endmodule

// File: rtl/bts_state_core.sv
module bts_state_core
  import burst_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fifo_has_data,
  input  logic      build_done,
  input  logic      build_overflow,
  input  logic      host_start,
  input  logic      host_reset,
  input  logic      slot_strobe,
  input  logic      cs_mode_en,
  input  logic      carrier_det,
  input  logic      eom_strobe,
  input  logic      dwell_expire,
  output tx_state_e state_q,
  output logic      tx_done,
  output logic      keep_rf_nxt,
  output logic      pa_on_nxt
);
  tx_state_e state_nxt;
  logic      chain_q, chain_nxt;
  logic      armed_q, armed_nxt;
  logic      done_nxt;

  always_comb begin
    state_nxt = state_q;
    chain_nxt = chain_q;
    armed_nxt = armed_q;
    done_nxt  = 1'b0;
    if (host_reset) begin
      state_nxt = ST_IDLE;
      chain_nxt = 1'b0;
      armed_nxt = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (host_start) armed_nxt = 1'b1;
          if (fifo_has_data) state_nxt = ST_BUILD;
        end
        ST_BUILD: begin
          if (build_overflow) begin
            state_nxt = ST_ERR_LONG;
            done_nxt  = 1'b1;
            chain_nxt = 1'b0;
            armed_nxt = 1'b0;
          end else if (build_done) begin
            state_nxt = (chain_q || armed_q || host_start) ? ST_PEND : ST_READY;
          end else if (slot_strobe) begin
            state_nxt = ST_ERR_LATE;
            done_nxt  = 1'b1;
            chain_nxt = 1'b0;
            armed_nxt = 1'b0;
          end else if (host_start) begin
            armed_nxt = 1'b1;
          end
        end
        ST_READY: begin
          if (host_start) state_nxt = ST_PEND;
        end
        ST_PEND: begin
          if (slot_strobe) begin
            chain_nxt = 1'b0;
            armed_nxt = 1'b0;
            if (cs_mode_en && carrier_det) begin
              state_nxt = ST_ERR_BUSY;
              done_nxt  = 1'b1;
            end else begin
              state_nxt = ST_ACTIVE;
            end
          end
        end
        ST_ACTIVE: begin
          if (eom_strobe) begin
            if (fifo_has_data) begin
              state_nxt = ST_CHAIN;
              chain_nxt = 1'b1;
            end else begin
              state_nxt = ST_IDLE;
              done_nxt  = 1'b1;
            end
          end
        end
        ST_CHAIN: begin
          if (dwell_expire) state_nxt = ST_BUILD;
        end
        ST_ERR_LONG: state_nxt = ST_ERR_LONG;
        ST_ERR_LATE: begin
          if (build_done)      state_nxt = (armed_q || host_start) ? ST_PEND : ST_READY;
          else if (host_start) armed_nxt = 1'b1;
        end
        ST_ERR_BUSY: begin
          if (host_start) state_nxt = ST_PEND;
        end
        default: state_nxt = ST_IDLE;
      endcase
    end
  end

  assign keep_rf_nxt = holds_rf(state_nxt, chain_nxt);
  assign pa_on_nxt   = (state_nxt == ST_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      chain_q <= 1'b0;
      armed_q <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      state_q <= state_nxt;
      chain_q <= chain_nxt;
      armed_q <= armed_nxt;
      tx_done <= done_nxt;
    end
  end
endmodule

// File: rtl/burst_tx_seq.sv
module burst_tx_seq
  import burst_tx_pkg::*;
#(
  parameter int unsigned RF_W        = 3,
  parameter int unsigned RAMP_CYCLES = 4,
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned DWELL_US    = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_has_data,
  input  logic            build_done,
  input  logic            build_overflow,
  input  logic            host_start,
  input  logic            host_reset,
  input  logic            slot_strobe,
  input  logic            cs_mode_en,
  input  logic            carrier_det,
  input  logic            eom_strobe,
  output logic [RF_W-1:0] rf_en,
  output logic            pa_ramp_up,
  output logic [3:0]      state_code,
  output logic            tx_done
);
  tx_state_e state_q;
  logic      keep_rf_nxt, pa_on_nxt, dwell_expire;

  bts_state_core u_core (
    .clk           (clk),
    .rst           (rst),
    .fifo_has_data (fifo_has_data),
    .build_done    (build_done),
    .build_overflow(build_overflow),
    .host_start    (host_start),
    .host_reset    (host_reset),
    .slot_strobe   (slot_strobe),
    .cs_mode_en    (cs_mode_en),
    .carrier_det   (carrier_det),
    .eom_strobe    (eom_strobe),
    .dwell_expire  (dwell_expire),
    .state_q       (state_q),
    .tx_done       (tx_done),
    .keep_rf_nxt   (keep_rf_nxt),
    .pa_on_nxt     (pa_on_nxt)
  );

  bts_dwell_timer #(.CLK_MHZ(CLK_MHZ), .DWELL_US(DWELL_US)) u_dwell (
    .clk   (clk),
    .rst   (rst),
    .run   (state_q == ST_CHAIN),
    .expire(dwell_expire)
  );

  bts_rf_sequencer #(.RF_W(RF_W), .RAMP_CYCLES(RAMP_CYCLES)) u_rf (
    .clk        (clk),
    .rst        (rst),
    .keep_rf_nxt(keep_rf_nxt),
    .pa_on_nxt  (pa_on_nxt),
    .rf_en      (rf_en),
    .pa_ramp_up (pa_ramp_up)
  );

  assign state_code = state_q;
endmodule

// File: rtl/burst_tx_seq_chk.sv
module burst_tx_seq_chk #(
  parameter int unsigned RF_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            fifo_has_data,
  input logic            host_reset,
  input logic            slot_strobe,
  input logic [RF_W-1:0] rf_en,
  input logic            pa_ramp_up,
  input logic [3:0]      state_code,
  input logic            tx_done
);
  // R1
  reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
    host_reset |=> state_code == 4'd0);

  // R3
  build_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd0 && fifo_has_data && !host_reset) |=> state_code == 4'd1);

  // R5
  active_rf_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd4 |-> (pa_ramp_up && (&rf_en)));

  // R5
  active_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code != 4'd4 && !host_reset && slot_strobe && state_code == 4'd3) |=>
      (state_code == 4'd4 || state_code == 4'd10));

  // R2
  pa_needs_rf_chk: assert property (@(posedge clk) disable iff (rst)
    pa_ramp_up |-> (&rf_en));

  // R7
  chain_rf_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'd5 |-> ((&rf_en) && !pa_ramp_up));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  // R6
  done_state_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (state_code == 4'd0 || state_code == 4'd8 ||
                 state_code == 4'd9 || state_code == 4'd10));

  // R10
  long_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd8 && !host_reset) |=> state_code == 4'd8);
endmodule

bind burst_tx_seq burst_tx_seq_chk #(.RF_W(RF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fifo_has_data(fifo_has_data),
  .host_reset   (host_reset),
  .slot_strobe  (slot_strobe),
  .rf_en        (rf_en),
  .pa_ramp_up   (pa_ramp_up),
  .state_code   (state_code),
  .tx_done      (tx_done)
);

// File: tb/test_burst_tx_seq.sv
module test_burst_tx_seq;
  localparam int unsigned RF_W     = 3;
  localparam int unsigned RAMP     = 4;
  localparam int unsigned CLK_MHZ  = 250;
  localparam int unsigned DWELL_US = 1;
  localparam int unsigned DWELL    = CLK_MHZ * DWELL_US;
  localparam int unsigned NVEC     = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo, bdone, bovf, start, hrst, strobe, csm, car, eom;
  logic [RF_W-1:0] rf_en;
  logic pa_ramp_up, tx_done;
  logic [3:0] state_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_tx_seq #(.RF_W(RF_W), .RAMP_CYCLES(RAMP), .CLK_MHZ(CLK_MHZ), .DWELL_US(DWELL_US)) i_burst_tx_seq (
    .clk(clk), .rst(rst), .fifo_has_data(fifo), .build_done(bdone), .build_overflow(bovf),
    .host_start(start), .host_reset(hrst), .slot_strobe(strobe), .cs_mode_en(csm),
    .carrier_det(car), .eom_strobe(eom), .rf_en(rf_en), .pa_ramp_up(pa_ramp_up),
    .state_code(state_code), .tx_done(tx_done)
  );

  // Row: {req, inputs{fifo,bdone,bovf,start,hrst,strobe,csm,car,eom}, state, done, pa}
  localparam logic [18:0] VEC [NVEC] = '{
    {4'd1,  9'b000000000, 4'd0,  1'b0, 1'b0},  // R1 idle holds
    {4'd3,  9'b100000000, 4'd1,  1'b0, 1'b0},  // R3 data starts build
    {4'd4,  9'b100100000, 4'd1,  1'b0, 1'b0},  // R4 early start
    {4'd4,  9'b110000000, 4'd3,  1'b0, 1'b0},  // R4 armed build -> pending
    {4'd4,  9'b100000000, 4'd3,  1'b0, 1'b0},  // R4 pending holds
    {4'd5,  9'b000001000, 4'd4,  1'b0, 1'b1},  // R5 strobe sends
    {4'd5,  9'b000000000, 4'd4,  1'b0, 1'b1},  // R5 holds
    {4'd6,  9'b000000001, 4'd0,  1'b1, 1'b0},  // R6 eom, fifo empty
    {4'd6,  9'b000000000, 4'd0,  1'b0, 1'b0},  // R6 single pulse
    {4'd3,  9'b100000000, 4'd1,  1'b0, 1'b0},  // R3
    {4'd4,  9'b110000000, 4'd2,  1'b0, 1'b0},  // R4 no start -> ready
    {4'd4,  9'b000001000, 4'd2,  1'b0, 1'b0},  // R4 strobe ignored in ready
    {4'd4,  9'b000100000, 4'd3,  1'b0, 1'b0},  // R4 start -> pending
    {4'd5,  9'b000001100, 4'd4,  1'b0, 1'b1},  // R5 mode on, channel clear
    {4'd6,  9'b000000001, 4'd0,  1'b1, 1'b0},  // R6
    {4'd3,  9'b100000000, 4'd1,  1'b0, 1'b0},  // R3
    {4'd8,  9'b000001000, 4'd9,  1'b1, 1'b0},  // R8 late buffer
    {4'd3,  9'b100000000, 4'd9,  1'b0, 1'b0},  // R3 fifo ignored in abort
    {4'd8,  9'b010000000, 4'd2,  1'b0, 1'b0},  // R8 build resumes -> ready
    {4'd4,  9'b000100000, 4'd3,  1'b0, 1'b0},  // R4
    {4'd9,  9'b000001110, 4'd10, 1'b1, 1'b0},  // R9 busy channel
    {4'd9,  9'b100000000, 4'd10, 1'b0, 1'b0},  // R9 holds
    {4'd9,  9'b000100000, 4'd3,  1'b0, 1'b0},  // R9 reschedule
    {4'd5,  9'b000001010, 4'd4,  1'b0, 1'b1},  // R5 carrier, mode off
    {4'd6,  9'b000000001, 4'd0,  1'b1, 1'b0},  // R6
    {4'd3,  9'b100000000, 4'd1,  1'b0, 1'b0},  // R3
    {4'd10, 9'b101000000, 4'd8,  1'b1, 1'b0},  // R10 overflow
    {4'd10, 9'b110101000, 4'd8,  1'b0, 1'b0},  // R10 sticky
    {4'd1,  9'b000010000, 4'd0,  1'b0, 1'b0},  // R1 reset leaves
    {4'd1,  9'b000000000, 4'd0,  1'b0, 1'b0}   // R1
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    @(negedge clk);
    {fifo, bdone, bovf, start, hrst, strobe, csm, car, eom} = v;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    {fifo, bdone, bovf, start, hrst, strobe, csm, car, eom} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1", "state", state_code, 0);
    check("R1", "done", tx_done, 0);
    check("R1", "pa", pa_ramp_up, 0);
    check("R1", "rf", rf_en, 0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][14:6]);
      step();
      check($sformatf("R%0d", VEC[i][18:15]), $sformatf("v%0d state", i), state_code, VEC[i][5:2]);
      check($sformatf("R%0d", VEC[i][18:15]), $sformatf("v%0d done", i), tx_done, VEC[i][1]);
      check($sformatf("R%0d", VEC[i][18:15]), $sformatf("v%0d pa", i), pa_ramp_up, VEC[i][0]);
    end

    // R6 release timing of the RF group
    drive(9'b100100000); step();
    drive(9'b010000000); step();
    drive(9'b000001000); step();
    check("R5", "rf on", rf_en, 7);
    drive(9'b000000001); step();
    check("R6", "state", state_code, 0);
    check("R6", "rf held", rf_en, 7);
    drive(9'b000000000);
    for (int k = 1; k < RAMP; k++) step();
    check("R6", "rf last high", rf_en, 7);
    step();
    check("R6", "rf cleared", rf_en, 0);

    // R2 host reset while transmitting
    drive(9'b100100000); step();
    drive(9'b010000000); step();
    drive(9'b000001000); step();
    drive(9'b000010000); step();
    check("R2", "state", state_code, 0);
    check("R2", "pa down", pa_ramp_up, 0);
    check("R2", "rf held", rf_en, 7);
    drive(9'b000000000);
    for (int k = 1; k < RAMP; k++) step();
    check("R2", "rf last high", rf_en, 7);
    step();
    check("R2", "rf cleared", rf_en, 0);

    // R1 reset beats a strobe in pending
    drive(9'b100100000); step();
    drive(9'b010000000); step();
    drive(9'b000011000); step();
    check("R1", "priority state", state_code, 0);
    check("R1", "priority rf", rf_en, 0);

    // R7 chained burst
    drive(9'b100100000); step();
    drive(9'b010000000); step();
    drive(9'b000001000); step();
    drive(9'b100000001); step();
    check("R7", "chain state", state_code, 5);
    check("R7", "chain pa", pa_ramp_up, 0);
    check("R7", "chain rf", rf_en, 7);
    drive(9'b100000000);
    for (int k = 1; k < DWELL; k++) begin
      step();
      if (state_code != 4'd5) check("R7", $sformatf("dwell at %0d", k), state_code, 5);
    end
    step();
    check("R7", "after dwell", state_code, 1);
    check("R7", "rf through build", rf_en, 7);
    drive(9'b010000000); step();
    check("R7", "pending without start", state_code, 3);
    drive(9'b000001000); step();
    check("R7", "second burst", state_code, 4);
    check("R7", "second pa", pa_ramp_up, 1);
    drive(9'b000000001); step();
    check("R6", "chain end state", state_code, 0);
    check("R6", "chain end done", tx_done, 1);
    drive(9'b000000000);
    repeat (RAMP) step();
    check("R6", "chain end rf", rf_en, 0);

    finish_run();
  end
endmodule